// File: doc/BRIEF.md
# Hex Record Stream Loader

This block consumes a stream of ASCII characters, one per cycle in which `ch_valid` is high, that carries a memory image in one of two common text record formats: colon-led Intel HEX records or S-led Motorola S-records. The first character of each record selects the format. The block turns each pair of hex digits into a byte and follows the record layout. Every data byte is sent to a byte-wide memory write port as soon as its second digit arrives.

Each record's checksum is checked against the rule for its format. A failure sets a sticky error flag and does not stop the load. Malformed input sets a sticky format error. The loader then drops the record and resynchronises on the next start character. When an end-of-file record arrives, the loader stops and reports the lowest and highest full addresses it wrote, together with the number of bytes written. A new load needs a reset.

Top module: `hexrec_loader`

## Requirements
- R1: After reset, `wr_en`, `done`, `err_csum` and `err_fmt` are 0, `byte_cnt` is 0, `lo_addr` is all ones and `hi_addr` is 0.
- R2: A colon starts an Intel record. Its fields are count, address high byte, address low byte, type and data, in that order. Each byte is two hex digits, high nibble first. For type 00, the data byte at position i is written to address + i. `wr_en` is high for exactly the one cycle that follows the clock edge that samples the byte's second digit. Records of any other type write nothing.
- R3: An Intel record is valid when the 8-bit sum of all its bytes, including the checksum, is 00. On a mismatch, `err_csum` is set and stays set. Data already written stays written.
- R4: An Intel record with type 01, or with a count of zero, sets `done` at its checksum byte. After that, no character causes a write or changes `byte_cnt`.
- R5: An S-record is the character `S`, then a type digit, then count, address, data and checksum. The count covers the address, data and checksum bytes. Types 1, 2 and 3 carry 2, 3 and 4 address bytes and write their data. `wr_addr` carries the low 16 bits of each byte address.
- R6: An S-record is valid when the 8-bit sum of its count, address, data and checksum bytes is FF. A mismatch sets the sticky `err_csum`.
- R7: A type 0 S-record (header) has its checksum checked but writes nothing.
- R8: S-record types 9, 8 and 7 use 2, 3 and 4 address bytes, write nothing, and set `done` at their checksum byte.
- R9: CR (0x0D) and LF (0x0A) between records are ignored. Hex digits are accepted in both upper and lower case.
- R10: Any character inside a record that is not a hex digit sets the sticky `err_fmt` and abandons the record, so it makes no further writes. If that character is a colon or `S`, it starts a new record.
- R11: `lo_addr` and `hi_addr` track the minimum and maximum full address written. `byte_cnt` counts the writes.
- R12: An S type digit of 4, or a character that is not a digit, sets `err_fmt`. An S count below the address width plus one also sets `err_fmt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | 1 | Character strobe |
| ch_data | input | 8 | ASCII character |
| wr_en | output | 1 | Memory byte write strobe |
| wr_addr | output | MEM_AW (16) | Low address bits for the write |
| wr_data | output | 8 | Byte to write |
| done | output | 1 | End-of-file record seen |
| err_csum | output | 1 | Sticky checksum error |
| err_fmt | output | 1 | Sticky format error |
| byte_cnt | output | CNT_W (16) | Number of bytes written |
| lo_addr | output | ADDR_W (32) | Lowest full address written |
| hi_addr | output | ADDR_W (32) | Highest full address written |

## Verification
The end-of-file decision and the checksum test both act on the same final byte of a record. A corrupted end record must therefore raise `done` and `err_csum` on the same clock edge. The bench provokes this by closing one load with an S8 record whose checksum has one bit flipped. It then checks that both flags are set and that no write follows. In the same way, a mid-record start character both flags a format error and opens a new record in one cycle. The bench checks that the write from the restarted record still arrives at the expected address.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_STYPE,
        LD_BYTES,
        LD_DONE
    } ld_state_e;

    typedef enum logic {
        REC_INTEL,
        REC_SREC
    } rec_kind_e;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_S     = 8'h53;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

    // address bytes carried by an S-record of the given type digit
    function automatic logic [2:0] srec_alen(input logic [3:0] t);
        case (t)
            4'd2, 4'd6, 4'd8: srec_alen = 3'd3;
            4'd3, 4'd7:       srec_alen = 3'd4;
            default:          srec_alen = 3'd2;
        endcase
    endfunction

    function automatic logic srec_writes(input logic [3:0] t);
        srec_writes = (t == 4'd1) || (t == 4'd2) || (t == 4'd3);
    endfunction

    function automatic logic srec_is_end(input logic [3:0] t);
        srec_is_end = (t == 4'd7) || (t == 4'd8) || (t == 4'd9);
    endfunction

endpackage

// File: rtl/hexrec_nibble.sv
module hexrec_nibble (
    input  logic [7:0] ascii_i,
    output logic       is_hex_o,
    output logic [3:0] nib_o
);
    always_comb begin
        is_hex_o = 1'b0;
        nib_o    = 4'h0;
        if (ascii_i >= 8'h30 && ascii_i <= 8'h39) begin
            is_hex_o = 1'b1;
            nib_o    = ascii_i[3:0];
        end else if ((ascii_i >= 8'h41 && ascii_i <= 8'h46) ||
                     (ascii_i >= 8'h61 && ascii_i <= 8'h66)) begin
            is_hex_o = 1'b1;
            nib_o    = ascii_i[3:0] + 4'd9;
        end
    end
endmodule

// File: rtl/hexrec_range.sv
module hexrec_range #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] lo_o,
    output logic [AW-1:0] hi_o
);
    typedef struct packed {
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
    } rng_t;

    rng_t rng_d, rng_q;

    always_comb begin
        rng_d = rng_q;
        if (upd_i) begin
            if (addr_i < rng_q.lo) rng_d.lo = addr_i;
            if (addr_i > rng_q.hi) rng_d.hi = addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rng_q.lo <= '1;
            rng_q.hi <= '0;
        end else begin
            rng_q <= rng_d;
        end
    end

    assign lo_o = rng_q.lo;
    assign hi_o = rng_q.hi;
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
    import hexrec_pkg::*;
#(
    parameter int MEM_AW = 16,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_valid,
    input  logic [7:0]        ch_data,
    output logic              wr_en,
    output logic [MEM_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              err_csum,
    output logic              err_fmt,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr
);
    localparam int IDX_W = 9;   // byte index within a record: up to 255 + 5

    typedef struct packed {
        ld_state_e         st;
        rec_kind_e         kind;
        logic              hi_seen;
        logic [3:0]        nib;
        logic [IDX_W-1:0]  idx;
        logic [7:0]        cnt;
        logic [7:0]        rtype;
        logic [7:0]        sum;
        logic [2:0]        alen;
        logic              wr_ok;
        logic [ADDR_W-1:0] addr;
        logic              wr_en;
        logic [MEM_AW-1:0] wr_addr;
        logic [7:0]        wr_data;
        logic              done;
        logic              err_csum;
        logic              err_fmt;
        logic [CNT_W-1:0]  bcnt;
    } ld_t;

    ld_t ld_d, ld_q;

    logic       is_hex;
    logic [3:0] nib;

    hexrec_nibble u_nib (
        .ascii_i  (ch_data),
        .is_hex_o (is_hex),
        .nib_o    (nib)
    );

    logic [7:0]       byte_v;
    logic [7:0]       sum_n;
    logic [IDX_W-1:0] last_idx;
    logic             is_last;
    logic             is_addr;
    logic             is_start;
    logic             is_crlf;
    logic             rec_end;

    always_comb begin
        byte_v   = {ld_q.nib, nib};
        sum_n    = ld_q.sum + byte_v;
        last_idx = (ld_q.kind == REC_INTEL) ? (IDX_W'(ld_q.cnt) + IDX_W'(4))
                                            : IDX_W'(ld_q.cnt);
        is_last  = (ld_q.idx != '0) && (ld_q.idx == last_idx);
        is_addr  = (ld_q.kind == REC_INTEL)
                 ? (ld_q.idx == IDX_W'(1) || ld_q.idx == IDX_W'(2))
                 : (ld_q.idx != '0 && ld_q.idx <= IDX_W'(ld_q.alen));
        is_start = (ch_data == CH_COLON) || (ch_data == CH_S);
        is_crlf  = (ch_data == CH_CR) || (ch_data == CH_LF);
        rec_end  = (ld_q.kind == REC_INTEL)
                 ? (ld_q.rtype == 8'h01 || ld_q.cnt == 8'h00)
                 : srec_is_end(ld_q.rtype[3:0]);

        ld_d       = ld_q;
        ld_d.wr_en = 1'b0;

        if (ch_valid && ld_q.st != LD_DONE) begin
            if (is_start) begin
                if (ld_q.st != LD_IDLE) ld_d.err_fmt = 1'b1;
                ld_d.st      = (ch_data == CH_COLON) ? LD_BYTES : LD_STYPE;
                ld_d.kind    = (ch_data == CH_COLON) ? REC_INTEL : REC_SREC;
                ld_d.idx     = '0;
                ld_d.hi_seen = 1'b0;
                ld_d.sum     = 8'h00;
                ld_d.addr    = '0;
                ld_d.alen    = 3'd2;
                ld_d.wr_ok   = 1'b0;
                ld_d.rtype   = 8'h00;
            end else begin
                case (ld_q.st)
                    LD_IDLE: begin
                        if (!is_crlf) ld_d.err_fmt = 1'b1;
                    end
                    LD_STYPE: begin
                        if (ch_data >= 8'h30 && ch_data <= 8'h39 && ch_data != 8'h34) begin
                            ld_d.rtype = {4'h0, ch_data[3:0]};
                            ld_d.alen  = srec_alen(ch_data[3:0]);
                            ld_d.wr_ok = srec_writes(ch_data[3:0]);
                            ld_d.sum   = 8'h01;   // S sums target FF: seed 1, compare to 0
                            ld_d.st    = LD_BYTES;
                        end else begin
                            ld_d.err_fmt = 1'b1;
                            ld_d.st      = LD_IDLE;
                        end
                    end
                    LD_BYTES: begin
                        if (!is_hex) begin
                            ld_d.err_fmt = 1'b1;
                            ld_d.st      = LD_IDLE;
                        end else if (!ld_q.hi_seen) begin
                            ld_d.nib     = nib;
                            ld_d.hi_seen = 1'b1;
                        end else begin
                            ld_d.hi_seen = 1'b0;
                            ld_d.sum     = sum_n;
                            ld_d.idx     = ld_q.idx + IDX_W'(1);
                            if (ld_q.idx == '0) begin
                                ld_d.cnt = byte_v;
                                if (ld_q.kind == REC_SREC &&
                                    byte_v < ({5'b0, ld_q.alen} + 8'd1)) begin
                                    ld_d.err_fmt = 1'b1;
                                    ld_d.st      = LD_IDLE;
                                end
                            end else if (is_last) begin
                                if (sum_n != 8'h00) ld_d.err_csum = 1'b1;
                                ld_d.st = LD_IDLE;
                                if (rec_end) begin
                                    ld_d.done = 1'b1;
                                    ld_d.st   = LD_DONE;
                                end
                            end else if (is_addr) begin
                                ld_d.addr = {ld_q.addr[ADDR_W-9:0], byte_v};
                            end else if (ld_q.kind == REC_INTEL && ld_q.idx == IDX_W'(3)) begin
                                ld_d.rtype = byte_v;
                                ld_d.wr_ok = (byte_v == 8'h00);
                            end else begin
                                if (ld_q.wr_ok) begin
                                    ld_d.wr_en   = 1'b1;
                                    ld_d.wr_addr = ld_q.addr[MEM_AW-1:0];
                                    ld_d.wr_data = byte_v;
                                    ld_d.bcnt    = ld_q.bcnt + CNT_W'(1);
                                end
                                ld_d.addr = ld_q.addr + ADDR_W'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q         <= '0;
            ld_q.st      <= LD_IDLE;
            ld_q.kind    <= REC_INTEL;
            ld_q.alen    <= 3'd2;
        end else begin
            ld_q <= ld_d;
        end
    end

    hexrec_range #(.AW(ADDR_W)) u_range (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (ld_d.wr_en),
        .addr_i (ld_q.addr),
        .lo_o   (lo_addr),
        .hi_o   (hi_addr)
    );

    assign wr_en    = ld_q.wr_en;
    assign wr_addr  = ld_q.wr_addr;
    assign wr_data  = ld_q.wr_data;
    assign done     = ld_q.done;
    assign err_csum = ld_q.err_csum;
    assign err_fmt  = ld_q.err_fmt;
    assign byte_cnt = ld_q.bcnt;
endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              done,
    input logic              err_csum,
    input logic              err_fmt,
    input logic [CNT_W-1:0]  byte_cnt,
    input logic [ADDR_W-1:0] lo_addr,
    input logic [ADDR_W-1:0] hi_addr
);
    // a byte needs two characters, so write pulses never touch
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_cnt_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> byte_cnt == $past(byte_cnt) + CNT_W'(1));

    assert_cnt_only_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt != $past(byte_cnt)) |-> wr_en);

    assert_range_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> lo_addr <= hi_addr);

    assert_done_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && !wr_en);

    assert_csum_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_csum |=> err_csum);

    assert_fmt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_fmt |=> err_fmt);
endmodule

bind hexrec_loader hexrec_loader_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .done     (done),
    .err_csum (err_csum),
    .err_fmt  (err_fmt),
    .byte_cnt (byte_cnt),
    .lo_addr  (lo_addr),
    .hi_addr  (hi_addr)
);

// File: tb/hexrec_loader_tb.sv
module hexrec_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_valid = 1'b0;
    logic [7:0]  ch_data = 8'h00;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        done, err_csum, err_fmt;
    logic [15:0] byte_cnt;
    logic [31:0] lo_addr, hi_addr;

    always #5 clk = ~clk;

    hexrec_loader u_dut (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
        .err_csum(err_csum), .err_fmt(err_fmt), .byte_cnt(byte_cnt),
        .lo_addr(lo_addr), .hi_addr(hi_addr)
    );

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    logic [15:0] q_addr[$];
    logic [7:0]  q_data[$];
    logic [31:0] m_lo, m_hi;
    int          m_cnt;
    logic [7:0]  dbuf [0:15];

    task automatic check_eq(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // write monitor: every pulse must match the next expected write
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            checks++;
            if (q_addr.size() == 0) begin
                fails++;
                $display("FAIL %s unexpected write actual=%h:%h expected=none",
                         cur_req, wr_addr, wr_data);
            end else begin
                logic [15:0] ea;
                logic [7:0]  ed;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                if (wr_addr !== ea || wr_data !== ed) begin
                    fails++;
                    $display("FAIL %s write actual=%h:%h expected=%h:%h",
                             cur_req, wr_addr, wr_data, ea, ed);
                end
            end
        end
    end

    function automatic logic [7:0] hexc(input logic [3:0] v, input bit lc);
        if (v < 4'd10) return 8'h30 + {4'h0, v};
        return (lc ? 8'h57 : 8'h37) + {4'h0, v};
    endfunction

    task automatic push_exp(input logic [31:0] a, input logic [7:0] d);
        q_addr.push_back(a[15:0]);
        q_data.push_back(d);
        if (a < m_lo) m_lo = a;
        if (a > m_hi) m_hi = a;
        m_cnt++;
    endtask

    task automatic send_char(input logic [7:0] c);
        if ($urandom % 5 == 0) begin
            @(negedge clk);
            ch_valid = 1'b0;
        end
        @(negedge clk);
        ch_valid = 1'b1;
        ch_data  = c;
    endtask

    task automatic send_byte(input logic [7:0] b);
        bit lc;
        lc = ($urandom % 2) == 1;
        send_char(hexc(b[7:4], lc));
        send_char(hexc(b[3:0], lc));
    endtask

    task automatic quiet(input int n);
        @(negedge clk);
        ch_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic crlf();
        send_char(8'h0D);
        send_char(8'h0A);
    endtask

    task automatic intel_rec(input int n, input logic [15:0] a, input logic [7:0] t,
                             input bit bad, input bit expw);
        logic [7:0] s;
        s = 8'(n) + a[15:8] + a[7:0] + t;
        for (int i = 0; i < n; i++) s = s + dbuf[i];
        if (expw && t == 8'h00)
            for (int i = 0; i < n; i++) push_exp({16'h0, a} + 32'(i), dbuf[i]);
        send_char(8'h3A);
        send_byte(8'(n));
        send_byte(a[15:8]);
        send_byte(a[7:0]);
        send_byte(t);
        for (int i = 0; i < n; i++) send_byte(dbuf[i]);
        send_byte((8'h00 - s) ^ (bad ? 8'h01 : 8'h00));
        crlf();
    endtask

    task automatic s_rec(input int typ, input logic [31:0] a, input int n,
                         input bit bad, input bit expw);
        int          al;
        logic [31:0] am;
        logic [7:0]  s, c;
        al = (typ == 2 || typ == 8) ? 3 : ((typ == 3 || typ == 7) ? 4 : 2);
        am = (al == 4) ? a : ((al == 3) ? {8'h0, a[23:0]} : {16'h0, a[15:0]});
        c  = 8'(al + n + 1);
        s  = c;
        for (int j = 0; j < al; j++) s = s + am[8*(al-1-j) +: 8];
        for (int i = 0; i < n; i++) s = s + dbuf[i];
        if (expw && typ >= 1 && typ <= 3)
            for (int i = 0; i < n; i++) push_exp(am + 32'(i), dbuf[i]);
        send_char(8'h53);
        send_char(8'h30 + 8'(typ));
        send_byte(c);
        for (int j = 0; j < al; j++) send_byte(am[8*(al-1-j) +: 8]);
        for (int i = 0; i < n; i++) send_byte(dbuf[i]);
        send_byte(~s ^ (bad ? 8'h01 : 8'h00));
        crlf();
    endtask

    task automatic fill_rand(input int n);
        for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
    endtask

    task automatic do_reset();
        ch_valid = 1'b0;
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_lo  = '1;
        m_hi  = '0;
        m_cnt = 0;
        q_addr.delete();
        q_data.delete();
    endtask

    task automatic end_phase(input string tag, input bit e_done,
                             input bit e_cs, input bit e_fmt);
        quiet(3);
        check_eq(tag, "pending writes", 32'(q_addr.size()), 32'd0);
        check_eq(tag, "done", {31'd0, done}, {31'd0, e_done});
        check_eq(tag, "err_csum", {31'd0, err_csum}, {31'd0, e_cs});
        check_eq(tag, "err_fmt", {31'd0, err_fmt}, {31'd0, e_fmt});
        check_eq(tag, "byte_cnt", {16'd0, byte_cnt}, 32'(m_cnt));
        check_eq(tag, "lo_addr", lo_addr, m_lo);
        check_eq(tag, "hi_addr", hi_addr, m_hi);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1f2e3d4c);

        // R1: reset state
        do_reset();
        @(negedge clk);
        check_eq("R1", "wr_en", {31'd0, wr_en}, 32'd0);
        check_eq("R1", "done", {31'd0, done}, 32'd0);
        check_eq("R1", "err_csum", {31'd0, err_csum}, 32'd0);
        check_eq("R1", "err_fmt", {31'd0, err_fmt}, 32'd0);
        check_eq("R1", "byte_cnt", {16'd0, byte_cnt}, 32'd0);
        check_eq("R1", "lo_addr", lo_addr, 32'hFFFF_FFFF);
        check_eq("R1", "hi_addr", hi_addr, 32'h0);

        // R2 R9 R11: random Intel data records, mixed case, blank lines
        cur_req = "R2";
        for (int k = 0; k < 8; k++) begin
            int n;
            n = 1 + int'($urandom % 12);
            fill_rand(n);
            intel_rec(n, 16'($urandom), 8'h00, 1'b0, 1'b1);
            if (k % 3 == 0) crlf();
        end
        // type 04 record: not a data record, writes nothing
        fill_rand(2);
        intel_rec(2, 16'h0000, 8'h04, 1'b0, 1'b1);
        cur_req = "R4";
        intel_rec(0, 16'h0000, 8'h01, 1'b0, 1'b1);
        // after end of file: nothing is written
        fill_rand(3);
        intel_rec(3, 16'h0400, 8'h00, 1'b0, 1'b0);
        end_phase("R4_R9_R11", 1'b1, 1'b0, 1'b0);

        // R3: bad checksum, data still written; zero count ends file
        do_reset();
        cur_req = "R3";
        dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
        intel_rec(3, 16'h8000, 8'h00, 1'b1, 1'b1);
        quiet(2);
        check_eq("R3", "err_csum after bad record", {31'd0, err_csum}, 32'd1);
        fill_rand(2);
        intel_rec(2, 16'h0010, 8'h00, 1'b0, 1'b1);
        cur_req = "R4";
        intel_rec(0, 16'h0000, 8'h00, 1'b0, 1'b1);
        end_phase("R3_R4", 1'b1, 1'b1, 1'b0);

        // R5 R6 R7 R8: S-records of each address width
        do_reset();
        cur_req = "R7";
        for (int i = 0; i < 5; i++) dbuf[i] = 8'h41 + 8'(i);
        s_rec(0, 32'h0, 5, 1'b0, 1'b1);
        cur_req = "R5";
        for (int k = 0; k < 9; k++) begin
            int n;
            n = 1 + int'($urandom % 10);
            fill_rand(n);
            s_rec(1 + (k % 3), $urandom, n, 1'b0, 1'b1);
        end
        dbuf[0] = 8'h5A;
        s_rec(3, 32'h7FFF_FFFF, 1, 1'b0, 1'b1);
        cur_req = "R8";
        s_rec(9, 32'h0000_1234, 0, 1'b0, 1'b1);
        fill_rand(2);
        s_rec(1, 32'h0000_2000, 2, 1'b0, 1'b0);
        end_phase("R5_R6_R8_R11", 1'b1, 1'b0, 1'b0);

        // R6 R7: bad S checksums; corrupted end record sets done and error together
        do_reset();
        cur_req = "R6";
        dbuf[0] = 8'hA5; dbuf[1] = 8'h5A;
        s_rec(1, 32'h0000_0300, 2, 1'b1, 1'b1);
        quiet(2);
        check_eq("R6", "err_csum after bad S1", {31'd0, err_csum}, 32'd1);
        do_reset();
        cur_req = "R7";
        s_rec(0, 32'h0, 2, 1'b1, 1'b1);
        quiet(2);
        check_eq("R7", "err_csum after bad header", {31'd0, err_csum}, 32'd1);
        check_eq("R7", "byte_cnt after header", {16'd0, byte_cnt}, 32'd0);
        do_reset();
        cur_req = "R8";
        s_rec(8, 32'h0012_3456, 0, 1'b1, 1'b1);
        end_phase("R8_R6", 1'b1, 1'b1, 1'b0);

        // R10 R12: format errors and resynchronisation
        do_reset();
        cur_req = "R10";
        send_char(8'h3A);
        send_byte(8'h02); send_byte(8'h10); send_byte(8'h00); send_byte(8'h00);
        push_exp(32'h1000, 8'hAA);
        send_byte(8'hAA);
        send_char(8'h47);                       // 'G' inside record
        send_byte(8'hBB);                       // stray digits: record was dropped
        quiet(2);
        check_eq("R10", "err_fmt after bad char", {31'd0, err_fmt}, 32'd1);
        check_eq("R10", "byte_cnt after abandon", {16'd0, byte_cnt}, 32'd1);
        crlf();
        send_char(8'h3A);
        send_byte(8'h05);
        send_byte(8'h30);
        dbuf[0] = 8'h77;
        intel_rec(1, 16'h2000, 8'h00, 1'b0, 1'b1);  // starts mid record: resync
        cur_req = "R12";
        send_char(8'h53); send_char(8'h34);     // type digit 4
        send_byte(8'h03);
        crlf();
        send_char(8'h53); send_char(8'h31);     // S1 with count 02: too short
        send_byte(8'h02); send_byte(8'h00); send_byte(8'h00);
        crlf();
        dbuf[0] = 8'h99;
        s_rec(1, 32'h0000_0040, 1, 1'b0, 1'b1);
        s_rec(7, 32'h0, 0, 1'b0, 1'b1);
        end_phase("R10_R12", 1'b1, 1'b0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=150000 cycles expected=finish earlier");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule